// File: doc/BRIEF.md
# Four-Channel Programmable DMA Controller

A request-driven transfer sequencer with four channels, programmed through a byte-wide register port. Each channel holds a 16-bit current address and a 16-bit current count, together with base copies of both. Each channel also has a mode (direction, auto-reload, pass-through) and a mask bit. A peripheral raises its request line. Once granted, the channel drives one address on the memory side, acknowledges the peripheral, and then advances its address and count.

The 16-bit registers are reached one byte at a time. An internal byte-order flip-flop decides whether the low or the high half is hit. A dedicated strobe register returns that flip-flop to the low byte. Software loads the count as length minus one. Terminal count is raised on the transfer that finds the count at zero. After that transfer the channel either wraps the count to all ones or, with auto-reload, restores both base values. A channel in pass-through mode only relays the acknowledge to an external master for as long as that master holds its request.

Top module: `dmac4_core`

## Requirements
- R1: After reset every channel is masked, no acknowledge is driven, the status register reads 0x00 and the byte-order flip-flop points at the low byte.
- R2: Register offset 2n is channel n's address and offset 2n+1 is its count. Every read or write of these offsets toggles the byte-order flip-flop: the low byte is hit first and the high byte second. A write loads both the base and the current copy of that byte.
- R3: Any write to offset 11 forces the byte-order flip-flop back to the low byte.
- R4: Each grant to a non-pass-through channel lasts exactly one cycle. In that cycle dack_o carries the channel's bit, xfer_o is high and mem_addr_o equals the current address. Afterwards the address increments by one and the count decrements by one.
- R5: A count programmed as N-1 raises tc_o during the N-th transfer. Without auto-reload the count then reads 0xFFFF and the address keeps incrementing.
- R6: With auto-reload, the terminal-count transfer restores the current address and count from their base values.
- R7: Offset 9 is the mask register. Bits [1:0] select the channel, and bit 2 set to 1 masks the channel while 0 unmasks it. A masked channel's request yields no acknowledge and leaves its address unchanged.
- R8: Offset 10 is the mode register. Bits [1:0] select the channel and bits [3:2] set the direction: 2'b10 drives dir_rd_o high during the transfer, any other value drives it low. Bit 4 enables auto-reload. Bits [7:6] equal to 2'b11 select pass-through, and any other value selects single transfer.
- R9: A pass-through channel holds dack_o for as long as its request stays high. It never raises xfer_o and its address and count stay unchanged.
- R10: Offset 8 reads the terminal-count flags of channels 3..0 in bits [3:0], with the upper bits zero. A read clears the flags.
- R11: When several unmasked channels request at the same time, the lowest-numbered channel is granted first.
- R12: Reading back the address and count shows their progress after each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (toggles the byte order, clears status) |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| dreq_i | input | 4 | Per-channel request |
| dack_o | output | 4 | Per-channel acknowledge |
| mem_addr_o | output | 16 | Transfer address, valid while xfer_o is high |
| xfer_o | output | 1 | A single transfer occurs in this cycle |
| dir_rd_o | output | 1 | Transfer direction is memory read |
| tc_o | output | 1 | This transfer is the terminal-count transfer |

## Verification
A stuck byte-order flip-flop shows on the very next readback, because the bytes come back swapped or land in the wrong half. An address or count that advances wrongly shows one transfer later, either on mem_addr_o or in the cycle tc_o is raised. A lost auto-reload shows as an address that runs past the base range on the transfer after terminal count. Mask, priority and pass-through faults show in the first cycle after the grant edge, as a wrong dack_o pattern or a stray xfer_o.

// File: rtl/dmac4_pkg.sv
package dmac4_pkg;
  localparam int DW = 8;
  localparam int AW = 16;

  // mode register fields
  localparam int MD_DIR_LO  = 2;
  localparam int MD_AUTO    = 4;
  localparam int MD_TYPE_LO = 6;
  localparam logic [1:0] DIR_RD   = 2'b10;
  localparam logic [1:0] TYPE_PASS = 2'b11;
  // mask register field
  localparam int MK_SET = 2;

  typedef struct packed {
    logic pass;
    logic auto_rl;
    logic rd_dir;
  } chan_mode_t;

  function automatic chan_mode_t decode_mode(input logic [DW-1:0] v);
    chan_mode_t m;
    m.pass    = (v[MD_TYPE_LO +: 2] == TYPE_PASS);
    m.auto_rl = v[MD_AUTO];
    m.rd_dir  = (v[MD_DIR_LO +: 2] == DIR_RD);
    return m;
  endfunction
endpackage

// File: rtl/dmac4_chan.sv
module dmac4_chan
  import dmac4_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          cnt_we_i,
  input  logic          hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mode_we_i,
  input  logic          mask_we_i,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] cur_cnt_o,
  output chan_mode_t    mode_o,
  output logic          mask_o,
  output logic          tc_ev_o,
  output logic          tc_flag_o
);
  logic [AW-1:0] base_a, base_c, cur_a, cur_c;
  chan_mode_t    mode_q;
  logic          mask_q, flag_q;
  logic          tc_ev;

  assign tc_ev = step_i && (cur_c == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_a <= '0;
      cur_a  <= '0;
    end else if (addr_we_i) begin
      if (hi_i) begin
        base_a[AW-1:DW] <= wdata_i;
        cur_a[AW-1:DW]  <= wdata_i;
      end else begin
        base_a[DW-1:0] <= wdata_i;
        cur_a[DW-1:0]  <= wdata_i;
      end
    end else if (step_i) begin
      cur_a <= (tc_ev && mode_q.auto_rl) ? base_a : cur_a + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_c <= '0;
      cur_c  <= '0;
    end else if (cnt_we_i) begin
      if (hi_i) begin
        base_c[AW-1:DW] <= wdata_i;
        cur_c[AW-1:DW]  <= wdata_i;
      end else begin
        base_c[DW-1:0] <= wdata_i;
        cur_c[DW-1:0]  <= wdata_i;
      end
    end else if (step_i) begin
      cur_c <= (tc_ev && mode_q.auto_rl) ? base_c : cur_c - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= decode_mode(wdata_i);
      if (mask_we_i) mask_q <= wdata_i[MK_SET];
      if (tc_ev)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cur_addr_o = cur_a;
  assign cur_cnt_o  = cur_c;
  assign mode_o     = mode_q;
  assign mask_o     = mask_q;
  assign tc_ev_o    = tc_ev;
  assign tc_flag_o  = flag_q;

  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !tc_ev && !addr_we_i |=> cur_a == AW'($past(cur_a) + 1'b1));
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !tc_ev && !cnt_we_i |=> cur_c == AW'($past(cur_c) - 1'b1));
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_ev && !mode_q.auto_rl && !cnt_we_i |=> cur_c == '1);
  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_ev && mode_q.auto_rl && !cnt_we_i && !addr_we_i
    |=> cur_c == base_c && cur_a == base_a);
  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !tc_ev |=> !flag_q);
endmodule

// File: rtl/dmac4_arb.sv
module dmac4_arb #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] dreq_i,
  input  logic [NCH-1:0] mask_i,
  input  logic [NCH-1:0] pass_i,
  output logic [NCH-1:0] gnt_o
);
  logic [NCH-1:0] gnt_q, pick;
  logic           hold;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (dreq_i[i] && !mask_i[i]) pick = NCH'(1) << i;
  end

  assign hold = |(gnt_q & pass_i & dreq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gnt_q <= '0;
    else if (hold)        gnt_q <= gnt_q;
    else if (gnt_q != '0) gnt_q <= '0;
    else                  gnt_q <= pick;
  end

  assign gnt_o = gnt_q;

  // R11
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  // R4
  single_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q & ~pass_i) != '0 |=> gnt_q == '0);
  // R7
  mask_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i & ~gnt_q) != '0 |=> (gnt_q & $past(mask_i & ~gnt_q)) == '0);
endmodule

// File: rtl/dmac4_regif.sv
module dmac4_regif
  import dmac4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int RAW = $clog2(2 * NCH + 4),
  localparam int CSW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  input  logic [AW-1:0]  cur_addr_i [NCH],
  input  logic [AW-1:0]  cur_cnt_i  [NCH],
  input  logic [NCH-1:0] tc_flag_i,
  output logic [DW-1:0]  rdata_o,
  output logic           hi_o,
  output logic [NCH-1:0] addr_we_o,
  output logic [NCH-1:0] cnt_we_o,
  output logic [NCH-1:0] mode_we_o,
  output logic [NCH-1:0] mask_we_o,
  output logic           stat_rd_o
);
  localparam int OFS_STAT = 2 * NCH;
  localparam int OFS_MASK = 2 * NCH + 1;
  localparam int OFS_MODE = 2 * NCH + 2;
  localparam int OFS_CLR  = 2 * NCH + 3;

  logic           hi_q;
  logic           in_pair;
  logic [RAW-2:0] pair;
  logic [CSW-1:0] sel;

  assign in_pair = (int'(addr_i) < 2 * NCH);
  assign pair    = addr_i[RAW-1:1];
  assign sel     = wdata_i[CSW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   hi_q <= 1'b0;
    else if (we_i && int'(addr_i) == OFS_CLR)      hi_q <= 1'b0;
    else if ((we_i || re_i) && in_pair)            hi_q <= ~hi_q;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_strb
    assign addr_we_o[n] = we_i && in_pair && int'(pair) == n && !addr_i[0];
    assign cnt_we_o[n]  = we_i && in_pair && int'(pair) == n &&  addr_i[0];
    assign mode_we_o[n] = we_i && int'(addr_i) == OFS_MODE && int'(sel) == n;
    assign mask_we_o[n] = we_i && int'(addr_i) == OFS_MASK && int'(sel) == n;
  end

  always_comb begin
    logic [AW-1:0] w;
    rdata_o = '0;
    w       = '0;
    if (in_pair) begin
      w = addr_i[0] ? cur_cnt_i[pair[CSW-1:0]] : cur_addr_i[pair[CSW-1:0]];
      rdata_o = hi_q ? w[AW-1:DW] : w[DW-1:0];
    end else if (int'(addr_i) == OFS_STAT) begin
      rdata_o = DW'(tc_flag_i);
    end
  end

  assign hi_o      = hi_q;
  assign stat_rd_o = re_i && int'(addr_i) == OFS_STAT;

  // R3
  clr_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && int'(addr_i) == OFS_CLR |=> !hi_q);
  // R2
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || re_i) && in_pair |=> hi_q != $past(hi_q));
endmodule

// File: rtl/dmac4_core.sv
module dmac4_core
  import dmac4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int RAW = $clog2(2 * NCH + 4)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  input  logic           reg_we_i,
  input  logic           reg_re_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [NCH-1:0] dreq_i,
  output logic [NCH-1:0] dack_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           xfer_o,
  output logic           dir_rd_o,
  output logic           tc_o
);
  logic [AW-1:0]  cur_a [NCH];
  logic [AW-1:0]  cur_c [NCH];
  chan_mode_t     mode  [NCH];
  logic [NCH-1:0] mask, pass, tc_ev, tc_flag, step, gnt;
  logic [NCH-1:0] addr_we, cnt_we, mode_we, mask_we;
  logic           hi, stat_rd;

  dmac4_regif #(.NCH(NCH)) u_regif (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i), .re_i(reg_re_i),
    .cur_addr_i(cur_a), .cur_cnt_i(cur_c), .tc_flag_i(tc_flag),
    .rdata_o(reg_rdata_o), .hi_o(hi),
    .addr_we_o(addr_we), .cnt_we_o(cnt_we), .mode_we_o(mode_we), .mask_we_o(mask_we),
    .stat_rd_o(stat_rd)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dmac4_chan u_ch (
      .clk_i, .rst_ni,
      .addr_we_i(addr_we[n]), .cnt_we_i(cnt_we[n]), .hi_i(hi), .wdata_i(reg_wdata_i),
      .mode_we_i(mode_we[n]), .mask_we_i(mask_we[n]), .clr_i(stat_rd),
      .step_i(step[n]),
      .cur_addr_o(cur_a[n]), .cur_cnt_o(cur_c[n]), .mode_o(mode[n]),
      .mask_o(mask[n]), .tc_ev_o(tc_ev[n]), .tc_flag_o(tc_flag[n])
    );
    assign pass[n] = mode[n].pass;
  end

  dmac4_arb #(.NCH(NCH)) u_arb (
    .clk_i, .rst_ni, .dreq_i, .mask_i(mask), .pass_i(pass), .gnt_o(gnt)
  );

  assign step   = gnt & ~pass;
  assign dack_o = gnt;
  assign xfer_o = |step;
  assign tc_o   = |tc_ev;

  always_comb begin
    mem_addr_o = '0;
    dir_rd_o   = 1'b0;
    for (int n = 0; n < NCH; n++)
      if (step[n]) begin
        mem_addr_o = mem_addr_o | cur_a[n];
        dir_rd_o   = dir_rd_o | mode[n].rd_dir;
      end
  end

  // R9
  pass_no_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o & pass) != '0 |-> !xfer_o);
  // R1
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> dack_o == '0);
endmodule

// File: tb/dmac4_core_test.sv
module dmac4_core_test;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_ni = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       reg_we = 0, reg_re = 0;
  logic [3:0] dreq = 0, dack;
  logic [15:0] mem_addr;
  logic       xfer, dir_rd, tc;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dmac4_core uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_rdata_o(reg_rdata), .dreq_i(dreq), .dack_o(dack),
    .mem_addr_o(mem_addr), .xfer_o(xfer), .dir_rd_o(dir_rd), .tc_o(tc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1;
    #(CLK_P/4) d = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic wr16(logic [3:0] a, logic [15:0] v);
    wr(4'd11, 8'h00);
    wr(a, v[7:0]);
    wr(a, v[15:8]);
  endtask

  task automatic rd16(logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'd11, 8'h00);
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic do_xfer(int ch, logic [15:0] ea, logic etc, logic edir, string req);
    @(negedge clk) dreq[ch] = 1;
    @(negedge clk);
    chk(req, "dack", dack, 4'(1 << ch));
    chk(req, "xfer", xfer, 1);
    chk(req, "mem_addr", mem_addr, ea);
    chk(req, "tc", tc, etc);
    chk(req, "dir_rd", dir_rd, edir);
    dreq[ch] = 0;
    @(negedge clk);
    chk(req, "dack after transfer", dack, 0);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1", "dack at reset", dack, 0);
    rd(4'd8, s);
    chk("R1", "status at reset", s, 8'h00);
    @(negedge clk) dreq = 4'hF;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "masked after reset", dack, 0);
    end
    dreq = 0;
  endtask

  task automatic t_toggle();
    logic [15:0] v;
    wr(4'd11, 8'h00);
    wr(4'd0, 8'h34);
    wr(4'd0, 8'h12);
    wr(4'd1, 8'h02);
    wr(4'd1, 8'h00);
    rd16(4'd0, v);
    chk("R2", "ch0 address readback", v, 16'h1234);
    rd16(4'd1, v);
    chk("R2", "ch0 count readback", v, 16'h0002);
    wr(4'd2, 8'hAA);
    wr(4'd11, 8'h00);
    wr(4'd2, 8'h55);
    wr(4'd2, 8'h66);
    rd16(4'd2, v);
    chk("R3", "ch1 address after clear", v, 16'h6655);
  endtask

  task automatic t_single();
    logic [15:0] v;
    logic [7:0]  s;
    wr(4'd10, 8'h48);
    wr(4'd9, 8'h00);
    do_xfer(0, 16'h1234, 0, 1, "R4");
    rd16(4'd1, v);
    chk("R12", "ch0 count after one", v, 16'h0001);
    rd16(4'd0, v);
    chk("R12", "ch0 address after one", v, 16'h1235);
    do_xfer(0, 16'h1235, 0, 1, "R4");
    do_xfer(0, 16'h1236, 1, 1, "R5");
    rd16(4'd1, v);
    chk("R5", "ch0 count wraps", v, 16'hFFFF);
    rd16(4'd0, v);
    chk("R5", "ch0 address continues", v, 16'h1237);
    rd(4'd8, s);
    chk("R10", "status after ch0 tc", s, 8'h01);
    rd(4'd8, s);
    chk("R10", "status cleared by read", s, 8'h00);
  endtask

  task automatic t_auto();
    logic [15:0] v;
    logic [7:0]  s;
    wr16(4'd4, 16'h0100);
    wr16(4'd5, 16'h0001);
    wr(4'd10, 8'h56);
    wr(4'd9, 8'h02);
    do_xfer(2, 16'h0100, 0, 0, "R8");
    do_xfer(2, 16'h0101, 1, 0, "R6");
    rd16(4'd4, v);
    chk("R6", "ch2 address reloaded", v, 16'h0100);
    rd16(4'd5, v);
    chk("R6", "ch2 count reloaded", v, 16'h0001);
    do_xfer(2, 16'h0100, 0, 0, "R6");
    rd(4'd8, s);
    chk("R10", "status after ch2 tc", s, 8'h04);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr(4'd9, 8'h06);
    @(negedge clk) dreq[2] = 1;
    repeat (4) begin
      @(negedge clk);
      chk("R7", "masked request ignored", dack, 0);
    end
    dreq[2] = 0;
    rd16(4'd4, v);
    chk("R7", "masked address unchanged", v, 16'h0101);
    wr(4'd9, 8'h02);
    do_xfer(2, 16'h0101, 1, 0, "R7");
  endtask

  task automatic t_prio();
    @(negedge clk) dreq = 4'b0101;
    @(negedge clk);
    chk("R11", "lowest channel first", dack, 4'b0001);
    chk("R11", "ch0 address", mem_addr, 16'h1237);
    dreq = 4'b0100;
    @(negedge clk);
    chk("R11", "gap after grant", dack, 0);
    @(negedge clk);
    chk("R11", "ch2 next", dack, 4'b0100);
    chk("R11", "ch2 address", mem_addr, 16'h0100);
    dreq = 0;
    @(negedge clk);
  endtask

  task automatic t_pass();
    logic [15:0] v;
    logic [7:0]  s;
    wr16(4'd6, 16'h0F00);
    wr16(4'd7, 16'h0000);
    wr(4'd10, 8'hC3);
    wr(4'd9, 8'h03);
    @(negedge clk) dreq[3] = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R9", "pass-through dack held", dack, 4'b1000);
      chk("R9", "no xfer", xfer, 0);
    end
    dreq[3] = 0;
    @(negedge clk);
    chk("R9", "dack released", dack, 0);
    rd16(4'd6, v);
    chk("R9", "ch3 address unchanged", v, 16'h0F00);
    rd16(4'd7, v);
    chk("R9", "ch3 count unchanged", v, 16'h0000);
    rd(4'd8, s);
    chk("R9", "no ch3 tc", s[3], 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_toggle();
    t_single();
    t_auto();
    t_mask();
    t_prio();
    t_pass();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule